// File: doc/BRIEF.md
# Vector Shift-Round-Saturate Unit

This block narrows a vector of wide fixed-point accumulator lanes into a vector of narrower integer lanes. Every lane is handled on its own: it is shifted by a signed amount, rounded from the bits that the right shift discards, and then clamped to the range of the output type. The output type can be signed or unsigned. A single status bit records whether any lane has ever clamped. Software clears this bit.

A lane-width select picks one of four narrowings. 32-bit lanes can become 8-bit or 16-bit lanes, and 64-bit lanes (half as many of them) can become 16-bit or 32-bit lanes. The rounding style, saturation enable and symmetric-range options are global mode inputs that apply to the whole vector. There is one register stage: a vector presented with `valid_i` high appears on `data_o` one clock later, with `valid_o` high.

Top module: `srs_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. `data_o` loads only on a `valid_i` cycle and holds its value otherwise. After reset, `data_o`, `valid_o` and `sat_o` are zero.
- R2: `width_mode_i` selects the narrowing. 0: 32-bit lanes to 8-bit lanes. 1: 32-bit lanes to 16-bit lanes. 2: 64-bit lanes to 16-bit lanes. 3: 64-bit lanes to 32-bit lanes. Input lane k sits at bit k*IN_W of `acc_i` and output lane k sits at bit k*OUT_W of `data_o`. In modes 0 and 2, the upper half of `data_o` is zero.
- R3: `shift_i` is a signed 7-bit value. A positive value is an arithmetic right shift. A negative value is a left shift. Values above 59 act as 59 and values below -4 act as -4. A shift of zero or a left shift adds no rounding increment.
- R4: `round_mode_i` works on right shifts and uses the discarded bits. 0 truncates toward minus infinity. 1 rounds ties upward. 2 rounds ties to the even result. 3 rounds ties away from zero. Non-tie fractions above one half always round up, except in mode 0.
- R5: With `sat_en_i` high and signed output of n bits, results are clamped to the range -2^(n-1) to 2^(n-1)-1.
- R6: With `sym_sat_i` high and signed output, the lower bound becomes -2^(n-1)+1.
- R7: With `unsigned_i` high, results are clamped to the range 0 to 2^n-1, and `sym_sat_i` has no effect.
- R8: With `sat_en_i` low, each lane outputs the low n bits of its shifted and rounded value, and no saturation event is raised.
- R9: `sat_o` is set in the cycle `valid_o` rises if any active lane of that vector clamped. It then stays set.
- R10: `sat_clr_i` clears `sat_o` on the next clock. If a saturating vector is accepted in the same cycle, the set wins.
- R11: Rounding is applied before clamping, so a value that only goes out of range after rounding is clamped and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector is valid |
| acc_i | input | LANES*32 | Packed accumulator lanes |
| shift_i | input | 7 | Signed shift amount |
| width_mode_i | input | 2 | Narrowing select |
| round_mode_i | input | 2 | Rounding style |
| sat_en_i | input | 1 | Clamp to output range |
| sym_sat_i | input | 1 | Symmetric signed range |
| unsigned_i | input | 1 | Unsigned output type |
| sat_clr_i | input | 1 | Clear saturation status |
| valid_o | output | 1 | Output vector is valid |
| data_o | output | LANES*16 | Packed narrowed lanes |
| sat_o | output | 1 | Sticky saturation status |

## Verification
The hardest situation to reach is an exact rounding tie on a negative lane, and a tie whose rounded result crosses the clamp bound. In both cases the discarded bits must be exactly one half. The stimulus builds such values directly from the shift amount, for example -10 with a shift of 2, and 255 with a shift of 1 in 8-bit mode. It runs each one under every rounding mode and compares the result against a model that uses a remainder instead of bit slicing. A second hard case is a clear and a saturating vector arriving in the same cycle. The bench asserts both inputs on one edge.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int SHIFT_W   = 7;
  localparam int SHIFT_MAX = 59;
  localparam int SHIFT_MIN = -4;
  localparam int ACC_NARROW_W = 32;
  localparam int ACC_WIDE_W   = 64;

  typedef enum logic [1:0] {
    RND_FLOOR     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_EVEN = 2'd2,
    RND_HALF_AWAY = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    WM_32_TO_8  = 2'd0,
    WM_32_TO_16 = 2'd1,
    WM_64_TO_16 = 2'd2,
    WM_64_TO_32 = 2'd3
  } width_mode_e;
endpackage

// File: rtl/srs_round.sv
module srs_round
  import srs_pkg::*;
#(
  parameter int XW = 96
) (
  input  logic signed [XW-1:0] x_i,
  input  logic [5:0]           rs_i,
  input  rnd_mode_e            mode_i,
  output logic signed [XW-1:0] y_o
);
  localparam int IW = $clog2(XW);
  localparam logic [XW-1:0] ONE = {{(XW-1){1'b0}}, 1'b1};

  logic signed [XW-1:0] q;
  logic [XW-1:0] mask;
  logic [IW-1:0] idx;
  logic half, below, inc;

  always_comb begin
    q     = x_i >>> rs_i;
    idx   = IW'(rs_i) - IW'(1);
    half  = 1'b0;
    below = 1'b0;
    mask  = '0;
    if (rs_i != 6'd0) begin
      half  = x_i[idx];
      mask  = (ONE << idx) - ONE;
      below = |(x_i & mask);
    end
    unique case (mode_i)
      RND_FLOOR:     inc = 1'b0;
      RND_HALF_UP:   inc = half;
      RND_HALF_EVEN: inc = half & (below | q[0]);
      default:       inc = half & (below | ~x_i[XW-1]);
    endcase
    y_o = inc ? q + ONE : q;
  end
endmodule

// File: rtl/srs_lane.sv
module srs_lane
  import srs_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0]          x_i,
  input  logic signed [SHIFT_W-1:0] shamt_i,
  input  rnd_mode_e                rnd_i,
  input  logic                     sat_en_i,
  input  logic                     sym_i,
  input  logic                     uns_i,
  input  logic                     wide_i,
  output logic [IN_W/2-1:0]        y_o,
  output logic                     sat_o
);
  localparam int OUT_W = IN_W / 2;
  localparam int NAR_W = IN_W / 4;
  localparam int XW    = IN_W + 64;
  localparam logic signed [XW-1:0] ONE_S  = {{(XW-1){1'b0}}, 1'b1};
  localparam logic signed [XW-1:0] P_WIDE = ONE_S <<< (OUT_W - 1);
  localparam logic signed [XW-1:0] P_NAR  = ONE_S <<< (NAR_W - 1);

  logic signed [XW-1:0] xe, rnd_v, val, top, hi, lo, res;
  logic [5:0] rs;
  logic [2:0] ls;
  logic hi_clip, lo_clip;

  assign xe = {{64{x_i[IN_W-1]}}, x_i};
  assign rs = shamt_i[SHIFT_W-1] ? 6'd0 : shamt_i[5:0];
  assign ls = 3'(7'sd0 - shamt_i);

  srs_round #(.XW(XW)) u_round (
    .x_i   (xe),
    .rs_i  (rs),
    .mode_i(rnd_i),
    .y_o   (rnd_v)
  );

  always_comb begin
    val     = shamt_i[SHIFT_W-1] ? (xe <<< ls) : rnd_v;
    top     = wide_i ? P_WIDE : P_NAR;
    hi      = uns_i ? ((top <<< 1) - ONE_S) : (top - ONE_S);
    lo      = uns_i ? '0 : (sym_i ? (ONE_S - top) : -top);
    hi_clip = val > hi;
    lo_clip = val < lo;
    res     = val;
    if (sat_en_i && hi_clip) res = hi;
    else if (sat_en_i && lo_clip) res = lo;
    sat_o   = sat_en_i & (hi_clip | lo_clip);
    y_o     = wide_i ? OUT_W'(res) : OUT_W'(NAR_W'(res));
  end
endmodule

// File: rtl/srs_sat_sticky.sv
module srs_sat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/srs_unit.sv
module srs_unit
  import srs_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [LANES*32-1:0]     acc_i,
  input  logic signed [6:0]       shift_i,
  input  logic [1:0]              width_mode_i,
  input  logic [1:0]              round_mode_i,
  input  logic                    sat_en_i,
  input  logic                    sym_sat_i,
  input  logic                    unsigned_i,
  input  logic                    sat_clr_i,
  output logic                    valid_o,
  output logic [LANES*16-1:0]     data_o,
  output logic                    sat_o
);
  localparam int N_NAR   = LANES;
  localparam int N_WIDE  = LANES / 2;
  localparam int OUT_VW  = LANES * 16;
  localparam int NW_OUT  = ACC_NARROW_W / 2;
  localparam int WW_OUT  = ACC_WIDE_W / 2;

  width_mode_e wm;
  rnd_mode_e   rm;
  logic signed [SHIFT_W-1:0] sh_c;
  logic is64, wide;

  logic [NW_OUT-1:0] y_n [N_NAR];
  logic [WW_OUT-1:0] y_w [N_WIDE];
  logic [N_NAR-1:0]  s_n;
  logic [N_WIDE-1:0] s_w;
  logic [OUT_VW-1:0] data_d;
  logic sat_any;

  assign wm   = width_mode_e'(width_mode_i);
  assign rm   = rnd_mode_e'(round_mode_i);
  assign is64 = wm[1];
  assign wide = wm[0];

  always_comb begin
    if (shift_i > 7'(SHIFT_MAX))       sh_c = 7'(SHIFT_MAX);
    else if (shift_i < 7'(SHIFT_MIN))  sh_c = 7'(SHIFT_MIN);
    else                               sh_c = shift_i;
  end

  for (genvar i = 0; i < N_NAR; i++) begin : g_nar
    srs_lane #(.IN_W(ACC_NARROW_W)) u_lane (
      .x_i     (acc_i[ACC_NARROW_W*i +: ACC_NARROW_W]),
      .shamt_i (sh_c),
      .rnd_i   (rm),
      .sat_en_i(sat_en_i),
      .sym_i   (sym_sat_i),
      .uns_i   (unsigned_i),
      .wide_i  (wide),
      .y_o     (y_n[i]),
      .sat_o   (s_n[i])
    );
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    srs_lane #(.IN_W(ACC_WIDE_W)) u_lane (
      .x_i     (acc_i[ACC_WIDE_W*j +: ACC_WIDE_W]),
      .shamt_i (sh_c),
      .rnd_i   (rm),
      .sat_en_i(sat_en_i),
      .sym_i   (sym_sat_i),
      .uns_i   (unsigned_i),
      .wide_i  (wide),
      .y_o     (y_w[j]),
      .sat_o   (s_w[j])
    );
  end

  always_comb begin
    data_d = '0;
    unique case (wm)
      WM_32_TO_8:  for (int i = 0; i < N_NAR; i++)  data_d[8*i  +: 8]  = y_n[i][7:0];
      WM_32_TO_16: for (int i = 0; i < N_NAR; i++)  data_d[16*i +: 16] = y_n[i];
      WM_64_TO_16: for (int j = 0; j < N_WIDE; j++) data_d[16*j +: 16] = y_w[j][15:0];
      default:     for (int j = 0; j < N_WIDE; j++) data_d[32*j +: 32] = y_w[j];
    endcase
  end

  assign sat_any = is64 ? |s_w : |s_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_d;
    end
  end

  srs_sat_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (valid_i & sat_any),
    .clr_i (sat_clr_i),
    .flag_o(sat_o)
  );
endmodule

// File: rtl/srs_unit_chk.sv
module srs_unit_chk #(
  parameter int LANES = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                wide_i,
  input logic                sat_en_i,
  input logic                sat_clr_i,
  input logic                valid_o,
  input logic [LANES*16-1:0] data_o,
  input logic                sat_o
);
  localparam int HALF = LANES * 8;

  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_data_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  p_short_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (data_o[LANES*16-1:HALF] == '0));
  p_no_flag_unsat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_en_i && !sat_o && !sat_clr_i) |=> !sat_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_clr_i) |=> sat_o);
  p_rise_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_o && !valid_i) |=> !sat_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_clr_i && !valid_i) |=> !sat_o);
endmodule

bind srs_unit srs_unit_chk #(.LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .wide_i   (width_mode_i[0]),
  .sat_en_i (sat_en_i),
  .sat_clr_i(sat_clr_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .sat_o    (sat_o)
);

// File: tb/srs_unit_bench.sv
`timescale 1ns/1ps
module srs_unit_bench;
  localparam int LANES = 4;
  localparam int AW = LANES * 32;
  localparam int DW = LANES * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [AW-1:0] acc_i = '0;
  logic signed [6:0] shift_i = '0;
  logic [1:0] width_mode_i = '0, round_mode_i = '0;
  logic sat_en_i = 1'b0, sym_sat_i = 1'b0, unsigned_i = 1'b0, sat_clr_i = 1'b0;
  logic valid_o, sat_o;
  logic [DW-1:0] data_o;

  int total = 0, bad = 0;
  bit exp_sat = 1'b0;

  always #10 clk = ~clk;

  srs_unit #(.LANES(LANES)) u_srs_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .acc_i(acc_i),
    .shift_i(shift_i), .width_mode_i(width_mode_i), .round_mode_i(round_mode_i),
    .sat_en_i(sat_en_i), .sym_sat_i(sym_sat_i), .unsigned_i(unsigned_i),
    .sat_clr_i(sat_clr_i), .valid_o(valid_o), .data_o(data_o), .sat_o(sat_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_lane(input logic signed [127:0] x, input int n,
      input int sh_in, input int rm, input bit se, input bit sy, input bit un, output bit s);
    logic signed [127:0] v, q, rem, half, hi, lo, one;
    bit inc;
    int sh;
    one = 128'sd1;
    sh = sh_in;
    if (sh > 59) sh = 59;
    if (sh < -4) sh = -4;
    if (sh <= 0) v = x <<< (-sh);
    else begin
      q = x >>> sh;
      rem = x - (q <<< sh);
      half = one <<< (sh - 1);
      inc = 1'b0;
      if (rm != 0) begin
        if (rem > half) inc = 1'b1;
        else if (rem == half) begin
          case (rm)
            1: inc = 1'b1;
            2: inc = q[0];
            default: inc = (x >= 0);
          endcase
        end
      end
      v = inc ? q + one : q;
    end
    hi = un ? (one <<< n) - one : (one <<< (n - 1)) - one;
    lo = un ? 128'sd0 : (sy ? one - (one <<< (n - 1)) : -(one <<< (n - 1)));
    s = 1'b0;
    if (se && v > hi) begin v = hi; s = 1'b1; end
    else if (se && v < lo) begin v = lo; s = 1'b1; end
    ref_lane = 32'(v) & ((32'd1 << n) - 32'd1);
  endfunction

  // one vector through the unit, output and sticky flag compared
  task automatic run(string req, int wm, int sh, int rm, bit se, bit sy, bit un, bit clr,
      logic [63:0] l0, logic [63:0] l1, logic [63:0] l2, logic [63:0] l3);
    logic [63:0] lv [4];
    logic [DW-1:0] exp_d;
    logic [AW-1:0] a;
    logic signed [127:0] xs;
    logic [31:0] r;
    bit s, any;
    int n, ow;
    lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
    a = '0; exp_d = '0; any = 1'b0;
    n = (wm == 0) ? 8 : (wm == 3) ? 32 : 16;
    ow = n;
    if (wm >= 2) begin
      for (int j = 0; j < LANES / 2; j++) begin
        a[64*j +: 64] = lv[j];
        xs = {{64{lv[j][63]}}, lv[j]};
        r = ref_lane(xs, n, sh, rm, se, sy, un, s);
        any |= s;
        for (int b = 0; b < ow; b++) exp_d[ow*j + b] = r[b];
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        a[32*i +: 32] = lv[i][31:0];
        xs = {{96{lv[i][31]}}, lv[i][31:0]};
        r = ref_lane(xs, n, sh, rm, se, sy, un, s);
        any |= s;
        for (int b = 0; b < ow; b++) exp_d[ow*i + b] = r[b];
      end
    end
    @(negedge clk);
    acc_i = a; shift_i = 7'(sh); width_mode_i = 2'(wm); round_mode_i = 2'(rm);
    sat_en_i = se; sym_sat_i = sy; unsigned_i = un; sat_clr_i = clr; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    exp_sat = (exp_sat & ~clr) | any;
    check({req, " data"}, 64'(data_o), 64'(exp_d));
    check("R1 valid_o", 64'(valid_o), 64'd1);
    check({req, " R9 sat_o"}, 64'(sat_o), 64'(exp_sat));
  endtask

  task automatic do_clear();
    @(negedge clk);
    sat_clr_i = 1'b1;
    @(negedge clk);
    sat_clr_i = 1'b0;
    exp_sat = 1'b0;
    check("R10 clear", 64'(sat_o), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 reset data", 64'(data_o), 64'd0);
    check("R1 reset valid", 64'(valid_o), 64'd0);
    check("R1 reset sat", 64'(sat_o), 64'd0);
  endtask

  task automatic t_modes();
    run("R2 m0", 0, 4, 0, 1, 0, 0, 0, 64'h123, 64'hFFFFFF00, 64'h7F0, 64'h55);
    run("R2 m1", 1, 4, 0, 1, 0, 0, 0, 64'h12345, 64'hFFF80000, 64'h7FFF0, 64'h3);
    run("R2 m2", 2, 8, 0, 1, 0, 0, 0, 64'h0000_0000_0012_3456, 64'hFFFF_FFFF_FF00_0000, 0, 0);
    run("R2 m3", 3, 16, 0, 1, 0, 0, 0, 64'h0000_1234_5678_9ABC, 64'hFFFF_F000_0000_0000, 0, 0);
    do_clear();
  endtask

  task automatic t_round();
    for (int rm = 0; rm < 4; rm++) begin
      run("R4 ties", 1, 2, rm, 1, 0, 0, 0, 64'd6, 64'd10, 64'hFFFFFFFA, 64'hFFFFFFF6);
      run("R4 nontie", 1, 2, rm, 1, 0, 0, 0, 64'd7, 64'd5, 64'hFFFFFFF9, 64'hFFFFFFFB);
      run("R4 wide tie", 3, 33, rm, 1, 0, 0, 0, 64'h0000_0003_0000_0000, 64'hFFFF_FFFD_0000_0000, 0, 0);
    end
  endtask

  task automatic t_shift();
    run("R3 left4", 1, -4, 1, 1, 0, 0, 0, 64'h12, 64'hFFFFFFF0, 64'h7FF, 64'h0);
    run("R3 clamp lo", 1, -8, 1, 1, 0, 0, 0, 64'h12, 64'hFFFFFFF0, 64'h7FF, 64'h1);
    run("R3 clamp hi", 3, 63, 1, 1, 0, 0, 0, 64'h0400_0000_0000_0000, 64'hF800_0000_0000_0000, 0, 0);
    run("R3 zero", 1, 0, 1, 1, 0, 0, 0, 64'h1234, 64'hFFFF8000, 64'h7FFF, 64'h1);
    run("R3 shift59 narrow", 0, 59, 3, 1, 0, 0, 0, 64'h8000_0000, 64'h7FFF_FFFF, 64'h1, 64'h0);
    check("R3 no sat", 64'(sat_o), 64'd0);
  endtask

  task automatic t_sat();
    run("R5 signed", 0, 0, 0, 1, 0, 0, 0, 64'd200, 64'hFFFFFF00, 64'hFFFFFF80, 64'd127);
    do_clear();
    run("R6 sym", 0, 0, 0, 1, 1, 0, 0, 64'hFFFFFF80, 64'hFFFFFF00, 64'hFFFFFF81, 64'd300);
    do_clear();
    run("R7 uns", 0, 0, 0, 1, 1, 1, 0, 64'd300, 64'hFFFFFFFF, 64'd255, 64'd17);
    do_clear();
    run("R5 m3", 3, 0, 0, 1, 0, 0, 0, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000, 0, 0);
    do_clear();
    run("R8 trunc", 0, 0, 0, 0, 0, 0, 0, 64'd300, 64'hFFFFFE00, 64'hFFFFFF80, 64'd5);
    check("R8 no flag", 64'(sat_o), 64'd0);
    run("R8 trunc left", 2, -4, 0, 0, 0, 0, 0, 64'h0000_0000_0001_2345, 64'hFFFF_FFFF_FFFF_8000, 0, 0);
    check("R8 no flag left", 64'(sat_o), 64'd0);
  endtask

  task automatic t_round_ovf();
    run("R11 floor", 0, 1, 0, 1, 0, 0, 0, 64'd255, 64'd0, 64'd0, 64'd0);
    check("R11 floor no sat", 64'(sat_o), 64'd0);
    run("R11 up", 0, 1, 1, 1, 0, 0, 0, 64'd255, 64'd0, 64'd0, 64'd0);
    check("R11 sat set", 64'(sat_o), 64'd1);
  endtask

  task automatic t_sticky();
    run("R9 keep", 0, 0, 0, 1, 0, 0, 0, 64'd1, 64'd2, 64'd3, 64'd4);
    check("R9 sticky", 64'(sat_o), 64'd1);
    run("R10 set wins", 0, 0, 0, 1, 0, 0, 1, 64'd999, 64'd0, 64'd0, 64'd0);
    check("R10 set over clear", 64'(sat_o), 64'd1);
    run("R10 clear with clean", 0, 0, 0, 1, 0, 0, 1, 64'd1, 64'd0, 64'd0, 64'd0);
    check("R10 cleared", 64'(sat_o), 64'd0);
  endtask

  task automatic t_hold();
    logic [DW-1:0] held;
    run("R1 load", 1, 0, 0, 1, 0, 0, 0, 64'h11, 64'h22, 64'h33, 64'h44);
    held = data_o;
    @(negedge clk);
    acc_i = {AW{1'b1}}; width_mode_i = 2'd3;
    repeat (3) @(negedge clk);
    check("R1 hold data", 64'(data_o), 64'(held));
    check("R1 idle valid", 64'(valid_o), 64'd0);
  endtask

  initial begin : wdog
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes();
    t_round();
    t_shift();
    t_sat();
    do_clear();
    t_round_ovf();
    t_sticky();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule